// File: doc/BRIEF.md
# Four-Operation ALU with Status Flags

This block is a purely combinational arithmetic logic unit for a datapath. It takes two operands of a parameterised width and a 2-bit operation code. It returns a result word together with four status flags: zero, negative, carry and overflow. The flags describe the result for the current inputs. The block holds no state, so the surrounding pipeline decides when to capture the result and the flags.

Both arithmetic operations use one adder. For subtraction, every bit of the second operand is XORed with a subtract control and the adder's carry-in is tied to that same control. The adder builds per-bit generate and propagate terms and resolves carries in lookahead form inside 4-bit groups. A second lookahead level combines the group generate and propagate terms to form the carries between groups. A width that is not a multiple of four is zero-padded up to the next whole group.

The block has no data stream, so it has no valid or ready handshake. All pins are plain control and data levels.

Top module: `alu_core`

## Requirements
- R1: Operation code 2'b00 drives the result to the bitwise AND of the two operands.
- R2: Operation code 2'b01 drives the result to the bitwise OR of the two operands.
- R3: Operation code 2'b10 drives the result to (A + B) modulo 2^W.
- R4: Operation code 2'b11 drives the result to (A + ~B + 1) modulo 2^W, which equals A − B modulo 2^W.
- R5: The zero flag is 1 exactly when every bit of the result is 0, for all four operation codes.
- R6: The negative flag equals result bit W−1, for all four operation codes.
- R7: For operation codes 2'b00 and 2'b01, the carry and overflow flags are both 0.
- R8: For code 2'b10, carry is 1 exactly when the unsigned sum A + B is at least 2^W. For code 2'b11, carry is 1 exactly when A ≥ B as unsigned numbers, meaning no borrow.
- R9: For code 2'b10, overflow is 1 exactly when A and B have equal top bits and the result's top bit differs from them. For code 2'b11, overflow is 1 exactly when A and B have different top bits and the result's top bit differs from A's top bit.
- R10: The result and the flags follow any change of the inputs without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First operand |
| opb_i | input | W | Second operand |
| op_sel_i | input | 2 | Operation code (00 AND, 01 OR, 10 add, 11 subtract) |
| result_o | output | W | Selected result word |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Top bit of the result |
| carry_o | output | 1 | Adder carry-out for add and subtract, 0 otherwise |
| ovf_o | output | 1 | Signed overflow for add and subtract, 0 otherwise |

## Verification
The block holds no state, so any internal fault shows at the ports within the same evaluation in which the inputs change. A wrong group or inter-group carry corrupts the result bits above the point of the fault. It also corrupts the carry and overflow flags whenever a carry chain crosses a 4-bit boundary. For this reason the stimulus mixes random operands with directed chains that carry through the full width. A wrong operand inversion or a wrong carry-in shows up as a result that is off by one or complemented on subtract, and as a wrong borrow indication on the carry flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;

  localparam int unsigned GRP_BITS = 4;
endpackage

// File: rtl/alu_cla_group.sv
module alu_cla_group (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       cin_i,
  output logic [3:0] sum_o,
  output logic [3:0] cout_o,   // cout_o[k] is the carry out of bit k
  output logic       grp_gen_o,
  output logic       grp_prop_o
);
  logic [3:0] g, p;

  assign g = a_i & b_i;
  assign p = a_i ^ b_i;

  // Every carry is expanded directly from g/p and the group carry-in.
  assign cout_o[0] = g[0] | (p[0] & cin_i);
  assign cout_o[1] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin_i);
  assign cout_o[2] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                   | (p[2] & p[1] & p[0] & cin_i);
  assign cout_o[3] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0])
                   | (p[3] & p[2] & p[1] & p[0] & cin_i);

  assign sum_o = p ^ {cout_o[2:0], cin_i};

  assign grp_gen_o  = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                    | (p[3] & p[2] & p[1] & g[0]);
  assign grp_prop_o = &p;
endmodule

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o   // carry into bit W-1
);
  localparam int unsigned NGRP = (W + alu_pkg::GRP_BITS - 1) / alu_pkg::GRP_BITS;
  localparam int unsigned PW   = NGRP * alu_pkg::GRP_BITS;

  logic [PW-1:0] a_pad, b_pad, sum_pad;
  logic [PW:0]   c_all;
  logic [NGRP-1:0] gg, gp;
  logic [NGRP:0]   gc;

  assign a_pad = PW'(a_i);
  assign b_pad = PW'(b_i);
  assign c_all[0] = cin_i;

  // Second lookahead level: carry into each group from group G/P terms.
  always_comb begin
    logic acc, term;
    gc[0] = cin_i;
    for (int j = 1; j <= int'(NGRP); j++) begin
      acc = 1'b0;
      for (int k = 0; k < j; k++) begin
        term = gg[k];
        for (int m = k + 1; m < j; m++) term = term & gp[m];
        acc = acc | term;
      end
      term = cin_i;
      for (int m = 0; m < j; m++) term = term & gp[m];
      gc[j] = acc | term;
    end
  end

  for (genvar j = 0; j < NGRP; j++) begin : g_grp
    alu_cla_group u_grp (
      .a_i       (a_pad[4*j +: 4]),
      .b_i       (b_pad[4*j +: 4]),
      .cin_i     (gc[j]),
      .sum_o     (sum_pad[4*j +: 4]),
      .cout_o    (c_all[4*j+1 +: 4]),
      .grp_gen_o (gg[j]),
      .grp_prop_o(gp[j])
    );
  end

  assign sum_o  = sum_pad[W-1:0];
  assign cout_o = c_all[W];
  assign cmsb_o = c_all[W-1];

  // The group-level lookahead must agree with each group's own last carry.
  always_comb begin
    for (int j = 1; j <= int'(NGRP); j++) begin
      AST_GROUP_CARRY: assert (gc[j] == c_all[4*j]); // R3
    end
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         arith_i,
  input  logic         cout_i,
  input  logic         cmsb_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o
);
  assign zero_o  = ~|res_i;
  assign neg_o   = res_i[W-1];
  assign carry_o = arith_i & cout_i;
  assign ovf_o   = arith_i & (cmsb_i ^ cout_i);
endmodule

// File: rtl/alu_core.sv
module alu_core #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [1:0]   op_sel_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o
);
  import alu_pkg::*;

  alu_op_e      op;
  logic         sub_en, arith_en;
  logic [W-1:0] b_eff, sum, res;
  logic         cout, cmsb;

  assign op       = alu_op_e'(op_sel_i);
  assign sub_en   = (op == OP_SUB);
  assign arith_en = (op == OP_ADD) || (op == OP_SUB);
  assign b_eff    = opb_i ^ {W{sub_en}};

  alu_cla_adder #(.W(W)) u_add (
    .a_i   (opa_i),
    .b_i   (b_eff),
    .cin_i (sub_en),
    .sum_o (sum),
    .cout_o(cout),
    .cmsb_o(cmsb)
  );

  always_comb begin
    unique case (op)
      OP_AND:  res = opa_i & opb_i;
      OP_OR:   res = opa_i | opb_i;
      default: res = sum;
    endcase
  end

  assign result_o = res;

  alu_flags #(.W(W)) u_flags (
    .res_i  (res),
    .arith_i(arith_en),
    .cout_i (cout),
    .cmsb_i (cmsb),
    .zero_o (zero_o),
    .neg_o  (neg_o),
    .carry_o(carry_o),
    .ovf_o  (ovf_o)
  );

  always_comb begin
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R5
    AST_NEG_MSB: assert (neg_o == result_o[W-1]); // R6
    if (op == OP_ADD) begin
      AST_ADD_SUM: assert (result_o == W'(opa_i + opb_i)); // R3
    end
    if (op == OP_SUB) begin
      AST_SUB_DIFF: assert (result_o == W'(opa_i - opb_i)); // R4
      AST_SUB_BORROW: assert (carry_o == (opa_i >= opb_i)); // R8
    end
    if (!arith_en) begin
      AST_LOGIC_NO_FLAGS: assert (!carry_o && !ovf_o); // R7
    end
  end
endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [W-1:0] opa, opb, res;
  logic [1:0]   op;
  logic         z, n, c, v;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu_core #(.W(W)) dut_i (
    .opa_i(opa), .opb_i(opb), .op_sel_i(op),
    .result_o(res), .zero_o(z), .neg_o(n), .carry_o(c), .ovf_o(v)
  );

  // Expected {zero, neg, carry, ovf, result} from the requirements.
  function automatic logic [W+3:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] o);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         cy, ov;
    cy = 1'b0; ov = 1'b0;
    case (o)
      2'b00: r = a & b;
      2'b01: r = a | b;
      2'b10: begin
        s = {1'b0, a} + {1'b0, b};
        r = s[W-1:0]; cy = s[W];
        ov = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      default: begin
        s = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
        r = s[W-1:0]; cy = (a >= b);
        ov = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
    endcase
    return {(r == '0), r[W-1], cy, ov, r};
  endfunction

  function automatic string res_tag(logic [1:0] o);
    case (o)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk1(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h", tag, what, op, opa, opb, act, exp);
    end
  endtask

  task automatic check_now();
    logic [W+3:0] e;
    e = model(opa, opb, op);
    chk1(res_tag(op), "result", res, e[W-1:0]);
    chk1("R5", "zero", W'(z), W'(e[W+3]));
    chk1("R6", "neg", W'(n), W'(e[W+2]));
    chk1(op[1] ? "R8" : "R7", "carry", W'(c), W'(e[W+1]));
    chk1(op[1] ? "R9" : "R7", "ovf", W'(v), W'(e[W]));
  endtask

  task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] o);
    @(negedge clk);
    opa = a; opb = b; op = o;
    #1;
    check_now();
  endtask

  initial begin
    opa = '0; opb = '0; op = 2'b00;
    @(negedge clk); #1;
    // Initial state: AND of zeros -> result 0, zero flag set (R1, R5, R7)
    check_now();

    apply(8'hF0, 8'h3C, 2'b00);   // R1
    apply(8'h55, 8'hAA, 2'b00);   // R1 zero result, R5
    apply(8'h50, 8'h0A, 2'b01);   // R2
    apply(8'h7F, 8'h01, 2'b10);   // R9 signed overflow on add
    apply(8'hFF, 8'h01, 2'b10);   // R8 carry, R5 zero
    apply(8'h0F, 8'h01, 2'b10);   // R3 carry across group boundary
    apply(8'h80, 8'h80, 2'b10);   // R8 carry and R9 overflow together
    apply(8'h05, 8'h05, 2'b11);   // R4 zero difference, R8 no borrow
    apply(8'h03, 8'h05, 2'b11);   // R8 borrow, R6 negative
    apply(8'h80, 8'h01, 2'b11);   // R9 overflow on subtract
    apply(8'h00, 8'h80, 2'b11);   // R9 0 - (-128)
    apply(8'h00, 8'h00, 2'b11);   // R8 equal operands give carry

    // R10: inputs change twice inside one clock period with no edge between.
    @(posedge clk); #0.5;
    opa = 8'h12; opb = 8'h34; op = 2'b10; #0.5;
    check_now(); // R10
    opa = 8'hFF; op = 2'b11; #0.5;
    check_now(); // R10

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      apply(W'($urandom), W'($urandom), 2'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule